// File: doc/BRIEF.md
# Inbound Address Decode Window Bank

This block holds a small bank of programmable windows that steer inbound memory requests. Each window has a control word (size, attribute, target id, enable), a base and a remap register. One more control word sets the size and enable of the inbound aperture. Every lookup address is first checked against that aperture. It is then compared with all enabled windows in parallel. The lowest-numbered matching window supplies the target id, the attribute and the translated address.

Configuration software first writes zero to every window and to the aperture word. It then programs one window per memory bank. Last, it writes the aperture word with the total bank size rounded up to a power of two. All sizes and bases use a 64 KiB granule. Lookups are presented one per cycle on a valid/address pair. The result comes out one clock later.

Top module: `iwd_window_bank`

## Requirements
- R1: After synchronous reset, every configuration register reads zero, `rsp_valid` is low, and every lookup misses.
- R2: A window control word keeps only bits 31:16 (size minus one, in 64 KiB units), 15:8 (attribute), 7:4 (target id) and 0 (enable); bits 3:1 read as zero. The base and remap registers keep only bits 31:16. The aperture word keeps bits 31:16 (size minus one) and bit 0 (enable).
- R3: Register offsets follow a fixed layout. Window n (n = 0..4) has its control word at n*0x10, its base at n*0x10+0x4 and its remap at n*0x10+0xC. Window 5 uses 0x60, 0x64 and 0x6C. The aperture word is at 0x70. A write to any other offset changes no register.
- R4: Window n hits when its enable is 1 and (addr & ~M) equals its base with the low 16 bits zero, where M = {size field, 16'hFFFF}.
- R5: When several windows hit, the lowest-numbered one is reported.
- R6: A hit reports the winning window's index on `rsp_win`, its target id on `rsp_target` and its attribute on `rsp_attr`.
- R7: On a hit, a remap register of zero gives `rsp_addr` = addr. Any other remap value gives (addr & M) | ({remap,16'h0} & ~M). The low 16 address bits always pass through unchanged.
- R8: A lookup that selects no window sets `rsp_miss`=1 and `rsp_hit`=0, forces `rsp_win`, `rsp_target` and `rsp_attr` to zero, and returns addr unchanged. `rsp_hit` and `rsp_miss` are never both set or both clear while `rsp_valid` is high.
- R9: The aperture gates the decode. If its enable bit is 0, or if addr has any bit set above {aperture size, 16'hFFFF}, the lookup misses whatever the windows hold.
- R10: `rsp_valid` rises exactly one cycle after each `lk_valid` and is low otherwise. Back-to-back lookups give back-to-back results.
- R11: The clear-then-program sequence (all registers to zero, one window per bank, then the aperture word) decodes each bank's addresses to its own window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration write byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_raddr | input | 8 | Configuration read byte offset |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| lk_valid | input | 1 | Lookup request valid |
| lk_addr | input | 32 | Lookup address |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | A window matched |
| rsp_miss | output | 1 | No window matched |
| rsp_win | output | 3 | Index of the winning window |
| rsp_target | output | 4 | Target id of the winning window |
| rsp_attr | output | 8 | Attribute of the winning window |
| rsp_addr | output | 32 | Translated address |

## Verification
The embedded properties assume that `lk_valid` and `lk_addr` are never unknown once reset is released. They also assume that reset is held long enough to clear the response register, since the latency and pass-through checks compare with the previous cycle's request. The stimulus drives every input on the falling edge from a known value and keeps reset low for several cycles. It also never leaves a configuration write pending across a lookup whose expectation depends on it, so the reference model in the bench sees register updates in the same order as the design.

// File: rtl/iwd_pkg.sv
// Shared widths, field positions and types for the inbound window bank.
// Assumes a 32-bit address space decoded on a 64 KiB granule.
package iwd_pkg;
    localparam int AW  = 32;          // address / register width
    localparam int GW  = 16;          // granule bits (64 KiB)
    localparam int HW  = AW - GW;     // upper address bits that are decoded
    localparam int ATW = 8;           // attribute width
    localparam int TGW = 4;           // target id width

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_TGT_LSB  = 4;
    localparam int CTL_ATTR_LSB = 8;

    typedef struct packed {
        logic [HW-1:0]  size_m1;
        logic [ATW-1:0] attr;
        logic [TGW-1:0] tgt;
        logic           en;
    } wctl_t;

    typedef struct packed {
        wctl_t         ctl;
        logic [HW-1:0] base;
        logic [HW-1:0] remap;
    } wcfg_t;

    // Split a written control word into its kept fields.
    function automatic wctl_t ctl_unpack(input logic [AW-1:0] w);
        wctl_t c;
        c.size_m1 = w[AW-1:GW];
        c.attr    = w[CTL_ATTR_LSB +: ATW];
        c.tgt     = w[CTL_TGT_LSB +: TGW];
        c.en      = w[CTL_EN_BIT];
        return c;
    endfunction

    // Rebuild the readable control word from its fields.
    function automatic logic [AW-1:0] ctl_pack(input wctl_t c);
        logic [AW-1:0] w;
        w = '0;
        w[AW-1:GW]               = c.size_m1;
        w[CTL_ATTR_LSB +: ATW]   = c.attr;
        w[CTL_TGT_LSB +: TGW]    = c.tgt;
        w[CTL_EN_BIT]            = c.en;
        return w;
    endfunction

    // Full-width mask: size field on top, granule bits all ones.
    function automatic logic [AW-1:0] hi_mask(input logic [HW-1:0] s);
        return {s, {GW{1'b1}}};
    endfunction
endpackage

// File: rtl/iwd_regs.sv
// Configuration register file of the window bank.
// Holds NWIN window register triples plus the aperture word. Windows
// 0..NWIN-2 sit on a STRIDE grid, the last window sits at LAST_OFF.
// Assumes cfg_addr/cfg_raddr are byte offsets; reads are combinational.
module iwd_regs
    import iwd_pkg::*;
#(
    parameter int NWIN     = 6,
    parameter int CFG_AW   = 8,
    parameter int STRIDE   = 16,
    parameter int LAST_OFF = 96,
    parameter int BAR_OFF  = 112
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [AW-1:0]     cfg_wdata,
    input  logic [CFG_AW-1:0] cfg_raddr,
    output logic [AW-1:0]     cfg_rdata,
    output wcfg_t             win_cfg [NWIN],
    output logic [HW-1:0]     bar_size_m1,
    output logic              bar_en
);
    localparam int CTL_O   = 0;
    localparam int BASE_O  = 4;
    localparam int REMAP_O = 12;

    // Bits of the write data that no register keeps.
    logic unused_wbits;
    assign unused_wbits = ^cfg_wdata[CTL_TGT_LSB-1:1];

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam int OFF = (g == NWIN - 1) ? LAST_OFF : g * STRIDE;

        // Capture writes aimed at this window's three registers.
        always_ff @(posedge clk) begin : win_wr_p
            if (!rst_n) begin
                win_cfg[g] <= '0;
            end else if (cfg_we) begin
                if (cfg_addr == CFG_AW'(OFF + CTL_O))
                    win_cfg[g].ctl <= ctl_unpack(cfg_wdata);
                if (cfg_addr == CFG_AW'(OFF + BASE_O))
                    win_cfg[g].base <= cfg_wdata[AW-1:GW];
                if (cfg_addr == CFG_AW'(OFF + REMAP_O))
                    win_cfg[g].remap <= cfg_wdata[AW-1:GW];
            end
        end
    end

    // Capture writes to the aperture word.
    always_ff @(posedge clk) begin : bar_wr_p
        if (!rst_n) begin
            bar_size_m1 <= '0;
            bar_en      <= 1'b0;
        end else if (cfg_we && cfg_addr == CFG_AW'(BAR_OFF)) begin
            bar_size_m1 <= cfg_wdata[AW-1:GW];
            bar_en      <= cfg_wdata[CTL_EN_BIT];
        end
    end

    // Read multiplexer over all registers; unmapped offsets read zero.
    always_comb begin : rd_mux_p
        cfg_rdata = '0;
        for (int i = 0; i < NWIN; i++) begin
            int off;
            off = (i == NWIN - 1) ? LAST_OFF : i * STRIDE;
            if (cfg_raddr == CFG_AW'(off + CTL_O))
                cfg_rdata = ctl_pack(win_cfg[i].ctl);
            if (cfg_raddr == CFG_AW'(off + BASE_O))
                cfg_rdata = {win_cfg[i].base, {GW{1'b0}}};
            if (cfg_raddr == CFG_AW'(off + REMAP_O))
                cfg_rdata = {win_cfg[i].remap, {GW{1'b0}}};
        end
        if (cfg_raddr == CFG_AW'(BAR_OFF))
            cfg_rdata = {bar_size_m1, {(GW-1){1'b0}}, bar_en};
    end
endmodule

// File: rtl/iwd_match.sv
// Single-window comparator and address translator.
// Assumes the base is aligned to the window size; a misaligned base
// simply never matches. Purely combinational.
module iwd_match
    import iwd_pkg::*;
(
    input  logic          en,
    input  logic [HW-1:0] size_m1,
    input  logic [HW-1:0] base,
    input  logic [HW-1:0] remap,
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [AW-1:0] xlat
);
    logic [AW-1:0] mask_w;
    logic [AW-1:0] base_w;
    logic [AW-1:0] remap_w;

    // Compare the address above the window size and build the translation.
    always_comb begin : match_p
        mask_w  = hi_mask(size_m1);
        base_w  = {base, {GW{1'b0}}};
        remap_w = {remap, {GW{1'b0}}};
        hit     = en && ((addr & ~mask_w) == base_w);
        if (remap == '0)
            xlat = addr;
        else
            xlat = (addr & mask_w) | (remap_w & ~mask_w);
    end
endmodule

// File: rtl/iwd_prio.sv
// Fixed-priority selector: lowest-numbered requester wins.
// Assumes hits is a plain vector of per-window matches.
module iwd_prio #(
    parameter int NWIN  = 6,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NWIN-1:0]  hits,
    output logic [NWIN-1:0]  grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // Walk upward and keep the first window that matched.
    always_comb begin : pick_p
        logic found;
        found = 1'b0;
        grant = '0;
        idx   = '0;
        for (int i = 0; i < NWIN; i++) begin
            if (hits[i] && !found) begin
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
                found    = 1'b1;
            end
        end
        any = found;
    end

    // R5
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R5
    grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hits != '0) |-> (grant == (hits & (~hits + NWIN'(1)))));
endmodule

// File: rtl/iwd_window_bank.sv
// Inbound address decode window bank (top).
// Gates each lookup by the aperture, matches it against all windows in
// parallel, picks the lowest-numbered hit and registers the result.
// Assumes one lookup per cycle; result latency is one clock.
module iwd_window_bank
    import iwd_pkg::*;
#(
    parameter int NWIN     = 6,
    parameter int CFG_AW   = 8,
    parameter int STRIDE   = 16,
    parameter int LAST_OFF = 96,
    parameter int BAR_OFF  = 112,
    localparam int IDX_W   = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [CFG_AW-1:0] cfg_raddr,
    output logic [31:0]       cfg_rdata,
    input  logic              lk_valid,
    input  logic [31:0]       lk_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [IDX_W-1:0]  rsp_win,
    output logic [3:0]        rsp_target,
    output logic [7:0]        rsp_attr,
    output logic [31:0]       rsp_addr
);
    wcfg_t            win_cfg [NWIN];
    logic [HW-1:0]    bar_size_m1;
    logic             bar_en;
    logic [NWIN-1:0]  hits;
    logic [AW-1:0]    xlat [NWIN];
    logic [NWIN-1:0]  grant;
    logic [IDX_W-1:0] sel_idx;
    logic             any_hit;
    logic             in_ap;
    logic             take;
    logic [TGW-1:0]   sel_tgt;
    logic [ATW-1:0]   sel_attr;
    logic [AW-1:0]    sel_xlat;

    iwd_regs #(
        .NWIN(NWIN), .CFG_AW(CFG_AW), .STRIDE(STRIDE),
        .LAST_OFF(LAST_OFF), .BAR_OFF(BAR_OFF)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .win_cfg(win_cfg), .bar_size_m1(bar_size_m1), .bar_en(bar_en)
    );

    for (genvar g = 0; g < NWIN; g++) begin : g_match
        iwd_match u_match (
            .en(win_cfg[g].ctl.en), .size_m1(win_cfg[g].ctl.size_m1),
            .base(win_cfg[g].base), .remap(win_cfg[g].remap),
            .addr(lk_addr), .hit(hits[g]), .xlat(xlat[g])
        );
    end

    iwd_prio #(.NWIN(NWIN), .IDX_W(IDX_W)) u_prio (
        .clk(clk), .rst_n(rst_n), .hits(hits),
        .grant(grant), .idx(sel_idx), .any(any_hit)
    );

    // Aperture gate: enabled and nothing set above the aperture size.
    always_comb begin : ap_p
        in_ap = bar_en && ((lk_addr & ~hi_mask(bar_size_m1)) == '0);
        take  = in_ap && any_hit;
    end

    // One-hot multiplexer for the winning window's fields.
    always_comb begin : sel_p
        sel_tgt  = '0;
        sel_attr = '0;
        sel_xlat = '0;
        for (int i = 0; i < NWIN; i++) begin
            if (grant[i]) begin
                sel_tgt  = sel_tgt  | win_cfg[i].ctl.tgt;
                sel_attr = sel_attr | win_cfg[i].ctl.attr;
                sel_xlat = sel_xlat | xlat[i];
            end
        end
    end

    // Register the lookup result one clock after the request.
    always_ff @(posedge clk) begin : rsp_p
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_miss   <= 1'b0;
            rsp_win    <= '0;
            rsp_target <= '0;
            rsp_attr   <= '0;
            rsp_addr   <= '0;
        end else begin
            rsp_valid <= lk_valid;
            if (lk_valid) begin
                rsp_hit    <= take;
                rsp_miss   <= !take;
                rsp_win    <= take ? sel_idx  : '0;
                rsp_target <= take ? sel_tgt  : '0;
                rsp_attr   <= take ? sel_attr : '0;
                rsp_addr   <= take ? sel_xlat : lk_addr;
            end
        end
    end

    // R10
    rsp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R10
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    // R8
    hit_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss));

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> (rsp_win == '0 && rsp_target == '0 && rsp_attr == '0));

    // R7
    low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rsp_addr[GW-1:0] == $past(lk_addr[GW-1:0])));
endmodule

// File: tb/iwd_window_bank_test.sv
// Scoreboard bench: the driver pushes expected results computed by a
// requirement-level model, the monitor pops and compares them.
module iwd_window_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [7:0]  cfg_raddr = '0;
    logic [31:0] cfg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [2:0]  rsp_win;
    logic [3:0]  rsp_target;
    logic [7:0]  rsp_attr;
    logic [31:0] rsp_addr;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct packed {
        logic        hit;
        logic        miss;
        logic [2:0]  win;
        logic [3:0]  tgt;
        logic [7:0]  attr;
        logic [31:0] addr;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    logic [31:0] sh_ctl   [6];
    logic [31:0] sh_base  [6];
    logic [31:0] sh_remap [6];
    logic [31:0] sh_bar;

    always #5 clk = ~clk;

    iwd_window_bank uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_win(rsp_win), .rsp_target(rsp_target), .rsp_attr(rsp_attr),
        .rsp_addr(rsp_addr)
    );

    function automatic int woff(int i);
        return (i == 5) ? 'h60 : i * 'h10;
    endfunction

    // Shadow copy of the register file per R2/R3.
    function automatic void sh_write(logic [7:0] off, logic [31:0] d);
        for (int i = 0; i < 6; i++) begin
            if (off == 8'(woff(i)))        sh_ctl[i]   = d & 32'hFFFF_FFF1;
            if (off == 8'(woff(i) + 4))    sh_base[i]  = d & 32'hFFFF_0000;
            if (off == 8'(woff(i) + 'hC))  sh_remap[i] = d & 32'hFFFF_0000;
        end
        if (off == 8'h70) sh_bar = d & 32'hFFFF_0001;
    endfunction

    function automatic logic [31:0] sh_read(logic [7:0] off);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < 6; i++) begin
            if (off == 8'(woff(i)))        r = sh_ctl[i];
            if (off == 8'(woff(i) + 4))    r = sh_base[i];
            if (off == 8'(woff(i) + 'hC))  r = sh_remap[i];
        end
        if (off == 8'h70) r = sh_bar;
        return r;
    endfunction

    // Expected lookup result per R4..R9.
    function automatic exp_t model(logic [31:0] a);
        exp_t e;
        logic [31:0] m;
        e = '0;
        e.miss = 1'b1;
        e.addr = a;
        if (!sh_bar[0] || ((a & ~{sh_bar[31:16], 16'hFFFF}) != 0)) return e;
        for (int i = 0; i < 6; i++) begin
            m = {sh_ctl[i][31:16], 16'hFFFF};
            if (sh_ctl[i][0] && ((a & ~m) == sh_base[i])) begin
                e.hit  = 1'b1;
                e.miss = 1'b0;
                e.win  = 3'(i);
                e.tgt  = sh_ctl[i][7:4];
                e.attr = sh_ctl[i][15:8];
                e.addr = (sh_remap[i] == 0) ? a : ((a & m) | (sh_remap[i] & ~m));
                return e;
            end
        end
        return e;
    endfunction

    task automatic wr(logic [7:0] off, logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = off; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        sh_write(off, d);
    endtask

    task automatic rd_chk(logic [7:0] off, logic [31:0] expv, string tag);
        cfg_raddr = off;
        #1;
        tests++;
        if (cfg_rdata !== expv) begin
            fails++;
            $display("FAIL %s: read 0x%02h got 0x%08h expected 0x%08h", tag, off, cfg_rdata, expv);
        end
        @(negedge clk);
    endtask

    // Drive one lookup for one cycle and queue its expected result.
    task automatic lk(logic [31:0] a, string tag);
        exp_q.push_back(model(a));
        tag_q.push_back(tag);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        lk_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Explicit expectation check against hand-computed values.
    task automatic spot(logic [31:0] a, logic h, logic [2:0] w, logic [31:0] xa, string tag);
        exp_t e;
        e = model(a);
        tests++;
        if (e.hit !== h || (h && (e.win !== w || e.addr !== xa))) begin
            fails++;
            $display("FAIL %s: model hit=%0d win=%0d addr=0x%08h expected hit=%0d win=%0d addr=0x%08h",
                     tag, e.hit, e.win, e.addr, h, w, xa);
        end
        lk(a, tag);
    endtask

    // Monitor: compare every result against the head of the scoreboard.
    always @(negedge clk) begin : mon_p
        if (rst_n && rsp_valid) begin
            exp_t  e;
            exp_t  got;
            string t;
            got = '{rsp_hit, rsp_miss, rsp_win, rsp_target, rsp_attr, rsp_addr};
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R10: unexpected result got %h expected none", got);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (got !== e) begin
                    fails++;
                    $display("FAIL %s: got hit=%0d miss=%0d win=%0d tgt=%0h attr=%02h addr=%08h expected hit=%0d miss=%0d win=%0d tgt=%0h attr=%02h addr=%08h",
                             t, got.hit, got.miss, got.win, got.tgt, got.attr, got.addr,
                             e.hit, e.miss, e.win, e.tgt, e.attr, e.addr);
                end
            end
        end
    end

    initial begin : watchdog_p
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : drv_p
        for (int i = 0; i < 6; i++) begin
            sh_ctl[i] = '0; sh_base[i] = '0; sh_remap[i] = '0;
        end
        sh_bar = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every register and of the lookup path
        tests++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: rsp_valid got %0b expected 0", rsp_valid);
        end
        for (int i = 0; i < 6; i++) begin
            rd_chk(8'(woff(i)),       32'h0, "R1 ctl");
            rd_chk(8'(woff(i) + 4),   32'h0, "R1 base");
            rd_chk(8'(woff(i) + 'hC), 32'h0, "R1 remap");
        end
        rd_chk(8'h70, 32'h0, "R1 aperture");
        spot(32'h0000_0000, 1'b0, 3'd0, 32'h0, "R1 R9 reset miss");
        idle(2);

        // R2: kept fields of each register kind
        wr(8'h00, 32'hFFFF_FFFF); rd_chk(8'h00, 32'hFFFF_FFF1, "R2 ctl fields");
        wr(8'h04, 32'hFFFF_FFFF); rd_chk(8'h04, 32'hFFFF_0000, "R2 base fields");
        wr(8'h0C, 32'hFFFF_FFFF); rd_chk(8'h0C, 32'hFFFF_0000, "R2 remap fields");
        wr(8'h70, 32'hFFFF_FFFF); rd_chk(8'h70, 32'hFFFF_0001, "R2 aperture fields");

        // R3: gaps are ignored, window 5 sits apart from the grid
        wr(8'h08, 32'h1234_5678);
        rd_chk(8'h08, 32'h0, "R3 gap offset");
        rd_chk(8'h00, 32'hFFFF_FFF1, "R3 gap leaves ctl");
        rd_chk(8'h10, 32'h0, "R3 gap leaves win1");
        wr(8'h6C, 32'hABCD_0000);
        rd_chk(8'h6C, 32'hABCD_0000, "R3 win5 remap");
        rd_chk(8'h4C, 32'h0, "R3 win4 remap untouched");

        // R11: clear everything, then program one window per bank
        for (int i = 0; i < 6; i++) begin
            wr(8'(woff(i)), 32'h0);
            wr(8'(woff(i) + 4), 32'h0);
            wr(8'(woff(i) + 'hC), 32'h0);
        end
        wr(8'h70, 32'h0);
        rd_chk(8'h6C, 32'h0, "R11 cleared");
        for (int b = 0; b < 2; b++) begin
            wr(8'(woff(b) + 4), 32'(b) << 28);
            wr(8'(woff(b) + 'hC), 32'h0);
            wr(8'(woff(b)), 32'h0FFF_0000 | (32'(8'h0E - b) << 8) | (32'(b) << 4) | 32'h1);
        end
        wr(8'h70, 32'h1FFF_0001);
        rd_chk(8'h10, 32'h0FFF_0D11, "R11 bank1 ctl");
        spot(32'h0000_1234, 1'b1, 3'd0, 32'h0000_1234, "R11 R4 bank0");
        spot(32'h1ABC_DEF0, 1'b1, 3'd1, 32'h1ABC_DEF0, "R11 R6 bank1");
        spot(32'h1FFF_FFFC, 1'b1, 3'd1, 32'h1FFF_FFFC, "R10 R4 back-to-back edge");
        spot(32'h2000_0000, 1'b0, 3'd0, 32'h2000_0000, "R9 above aperture");
        idle(2);

        // R5: overlapping windows, lowest index wins
        wr(8'h34, 32'h1000_0000);
        wr(8'h30, 32'h0000_3331);
        spot(32'h1000_0008, 1'b1, 3'd1, 32'h1000_0008, "R5 overlap picks win1");
        idle(1);
        wr(8'h10, 32'h0);
        spot(32'h1000_0008, 1'b1, 3'd3, 32'h1000_0008, "R5 R6 win3 after disable");
        spot(32'h1001_0000, 1'b0, 3'd0, 32'h1001_0000, "R4 R8 just past win3");
        idle(1);

        // R3: window 5 decodes at its separate offsets
        wr(8'h64, 32'h1800_0000);
        wr(8'h6C, 32'h0);
        wr(8'h60, 32'h0000_5551);
        spot(32'h1800_0010, 1'b1, 3'd5, 32'h1800_0010, "R3 R6 win5 hit");
        idle(1);

        // R7: translation through a remap register
        wr(8'h44, 32'h1C00_0000);
        wr(8'h4C, 32'h8000_0000);
        wr(8'h40, 32'h000F_4441);
        spot(32'h1C0F_2345, 1'b1, 3'd4, 32'h800F_2345, "R7 remap");
        idle(1);
        wr(8'h4C, 32'h8003_0000);
        spot(32'h1C0F_2345, 1'b1, 3'd4, 32'h800F_2345, "R7 remap low bits masked");
        idle(1);

        // R9: aperture disable and shrink
        wr(8'h70, 32'h0);
        spot(32'h0000_1234, 1'b0, 3'd0, 32'h0000_1234, "R9 aperture off");
        idle(1);
        wr(8'h70, 32'h0FFF_0001);
        spot(32'h1000_0008, 1'b0, 3'd0, 32'h1000_0008, "R9 small aperture");
        spot(32'h0000_1234, 1'b1, 3'd0, 32'h0000_1234, "R9 inside aperture");
        idle(3);

        // R10: nothing left outstanding
        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R10: outstanding results got %0d expected 0", exp_q.size());
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule